// File: doc/BRIEF.md
# System Reset Pulse Controller

This block owns the active-low system reset of the chip. The reset pin is shared: any device on the board may pull it low, and the block pulls it low itself. The pin is modelled as two signals. `pin_sense_n` is the level seen on the pin. `pin_drive_en` tells the pad to pull the pin low. The weak pull-up and the supply comparator are outside the block.

Three causes start a reset: a debounced external low on the pin (a manual switch), a low-supply indication, and a watchdog fault that the watchdog enable allows. Every cause feeds one pulse generator. That generator holds the pin low for a minimum number of millisecond ticks, counted from the most recent request. When the pulse ends, the block gives the watchdog a one-cycle release strobe.

Two sticky flags record why resets happened. Software reads them as one status byte and clears them with a write. A hardware event always wins over a clear that falls in the same cycle.

Top module: `rst_pulse_ctrl`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `pin_drive_en` is 0, `rst_release` is 0 and `reg_rdata` is 8'h00.
- R2: A manual request is accepted on the 4th consecutive `ms_tick` with `pin_sense_n` low. Any cycle with `pin_sense_n` high restarts the count. After only 3 ticks, or after a count that was interrupted, the pin is not driven.
- R3: A request makes `pin_drive_en` 1 from the cycle after the request is sampled. With PULSE_MS=100, the drive stays asserted through the 100th `ms_tick` after the last request. It is released in the cycle after the 101st such tick.
- R4: While `pin_drive_en` is 1, a low on `pin_sense_n` is ignored. Its own drive neither lengthens the pulse nor starts a new pulse after release.
- R5: `wdog_fault` requests a reset only in a cycle where `wdog_allow` is 1. With `wdog_allow` at 0 it changes neither the drive nor the flags.
- R6: A manual request or a supply-low request sets the power/manual flag, read at `reg_rdata` bit 6.
- R7: An allowed watchdog request sets the watchdog flag, read at `reg_rdata` bit 7. Bits 5..0 read 0. Both flags can read 1 together (8'hC0).
- R8: A cycle with `reg_wr` 1 clears each flag whose `reg_wdata` bit (7 for watchdog, 6 for power/manual) is 0. A flag whose bit is 1 keeps its value. Flags change only by hardware set or by this write.
- R9: A new request during a pulse restarts the count, so the pulse ends 101 ticks after that new request.
- R10: While `supply_low` is 1, the pin stays driven for any number of ticks. It is released on the 101st tick after the last cycle in which `supply_low` was 1.
- R11: If a flag is set by hardware and cleared by a write in the same cycle, the flag ends up set.
- R12: `rst_release` is 1 for exactly one cycle: the first cycle in which `pin_drive_en` is back at 0 after a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| ms_tick | input | 1 | One-cycle strobe each millisecond from the time base |
| pin_sense_n | input | 1 | Sensed level of the shared reset pin (0 = low) |
| supply_low | input | 1 | Low-supply indication, active high |
| wdog_fault | input | 1 | Watchdog timeout request |
| wdog_allow | input | 1 | Watchdog enable: lets a fault drive the reset |
| reg_wr | input | 1 | Write strobe to the status byte |
| reg_wdata | input | 8 | Write data: a 0 in bit 7 or bit 6 clears that flag |
| reg_rdata | output | 8 | Status byte: bit 7 watchdog flag, bit 6 power/manual flag |
| pin_drive_en | output | 1 | Pull the reset pin low |
| rst_release | output | 1 | One-cycle strobe when the pulse ends |

## Verification
Two things can fall in the same cycle: a hardware flag set and a software clear of that flag. The bench provokes this in two ways. It writes a clear to the power/manual flag while `supply_low` is held. It also issues an allowed watchdog fault in the same cycle as a write that clears both flags. It judges the result from the status byte on the next cycle, where the set flag must still read 1. A second overlap, a new request landing mid-pulse, is judged by counting ticks until the drive is released.

// File: rtl/rpc_pkg.sv
// Package rpc_pkg: shared constants and types for the reset pulse controller.
// Assumes an 8-bit status byte; flag bit positions are fixed for software.
package rpc_pkg;
    localparam int unsigned REG_W   = 8;
    localparam int unsigned WTR_POS = 7;   // watchdog cause flag
    localparam int unsigned POR_POS = 6;   // power / manual cause flag

    typedef struct packed {
        logic supply;
        logic manual;
        logic wdog;
    } rst_cause_t;
endpackage

// File: rtl/rpc_debounce.sv
// Module rpc_debounce: accepts an external low on the reset pin only after it
// has been seen low on TICKS consecutive millisecond ticks. Any high level, or
// the block's own drive, restarts the count.
// Assumes ms_tick is a one-cycle strobe and pin_low is already synchronised.
module rpc_debounce #(
    parameter int unsigned TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic pin_low,
    input  logic drive_active,
    output logic manual_req
);
    localparam int unsigned W = $clog2(TICKS + 1);

    logic [W-1:0] run;

    // Count consecutive low ticks; clear on high level or own drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= '0;
        end else if (!pin_low || drive_active) begin
            run <= '0;
        end else if (ms_tick && run != W'(TICKS)) begin
            run <= run + W'(1);
        end
    end

    // Request on the tick that completes the required run.
    assign manual_req = ms_tick && pin_low && !drive_active && (run == W'(TICKS - 1));

    // R2
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) run <= W'(TICKS));
    // R4
    no_self_trigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_active |=> (run == '0));
endmodule

// File: rtl/rpc_pulse_timer.sv
// Module rpc_pulse_timer: stretches any request into a reset pulse that lasts
// until PULSE_MS+1 ticks after the last request (at least PULSE_MS full
// milliseconds). Emits a one-cycle strobe when the pulse ends.
// Assumes req may be a level held for many cycles.
module rpc_pulse_timer #(
    parameter int unsigned PULSE_MS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic req,
    output logic active,
    output logic release_stb
);
    localparam int unsigned LOAD = PULSE_MS + 1;
    localparam int unsigned W    = $clog2(LOAD + 1);

    logic [W-1:0] remain;

    // Load on request, count down on ticks, end pulse on the last tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active      <= 1'b0;
            remain      <= '0;
            release_stb <= 1'b0;
        end else begin
            release_stb <= 1'b0;
            if (req) begin
                active <= 1'b1;
                remain <= W'(LOAD);
            end else if (active && ms_tick) begin
                if (remain == W'(1)) begin
                    active      <= 1'b0;
                    remain      <= '0;
                    release_stb <= 1'b1;
                end else begin
                    remain <= remain - W'(1);
                end
            end
        end
    end

    // R3
    end_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> ($past(ms_tick) && !$past(req)));
    // R12
    release_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        release_stb |-> (!active && $past(active)));
    // R12
    release_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        release_stb |=> !release_stb);
    // R9
    remain_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        remain <= W'(LOAD));
endmodule

// File: rtl/rpc_cause_flags.sv
// Module rpc_cause_flags: two sticky reset-cause flags. Hardware sets them;
// a register write with a 0 in a flag's bit clears it; set beats clear.
// Assumes set inputs are single-cycle or level; both are honoured each cycle.
module rpc_cause_flags
    import rpc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_por,
    input  logic             set_wtr,
    input  logic             wr_en,
    input  logic             keep_por,
    input  logic             keep_wtr,
    output logic [REG_W-1:0] rdata
);
    logic por_q;
    logic wtr_q;
    logic clr_por;
    logic clr_wtr;

    // Decode the clear request for each flag.
    always_comb begin
        clr_por = wr_en && !keep_por;
        clr_wtr = wr_en && !keep_wtr;
    end

    // Sticky flags: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            por_q <= 1'b0;
            wtr_q <= 1'b0;
        end else begin
            por_q <= set_por || (por_q && !clr_por);
            wtr_q <= set_wtr || (wtr_q && !clr_wtr);
        end
    end

    // Assemble the status byte.
    always_comb begin
        rdata          = '0;
        rdata[POR_POS] = por_q;
        rdata[WTR_POS] = wtr_q;
    end

    // R8
    por_clear_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(por_q) |-> ($past(wr_en) && !$past(keep_por)));
    // R8
    wtr_clear_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wtr_q) |-> ($past(wr_en) && !$past(keep_wtr)));
    // R6
    por_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(por_q) |-> $past(set_por));
    // R11
    wtr_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_wtr |=> wtr_q);
endmodule

// File: rtl/rst_pulse_ctrl.sv
// Module rst_pulse_ctrl: top of the system reset pulse controller. Merges the
// manual, low-supply and watchdog causes into one pulse on the shared pin and
// records the cause flags.
// Assumes pin_sense_n is synchronised to clk upstream; ms_tick is one cycle.
module rst_pulse_ctrl
    import rpc_pkg::*;
#(
    parameter int unsigned PULSE_MS       = 100,
    parameter int unsigned DEBOUNCE_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic             pin_sense_n,
    input  logic             supply_low,
    input  logic             wdog_fault,
    input  logic             wdog_allow,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             pin_drive_en,
    output logic             rst_release
);
    rst_cause_t cause;
    logic       manual_req;
    logic       any_req;
    logic       unused_wbits;

    assign unused_wbits = ^reg_wdata[POR_POS-1:0];

    rpc_debounce #(.TICKS(DEBOUNCE_TICKS)) u_debounce (
        .clk          (clk),
        .rst_n        (rst_n),
        .ms_tick      (ms_tick),
        .pin_low      (!pin_sense_n),
        .drive_active (pin_drive_en),
        .manual_req   (manual_req)
    );

    // Collect the three reset causes for this cycle.
    always_comb begin
        cause.supply = supply_low;
        cause.manual = manual_req;
        cause.wdog   = wdog_fault && wdog_allow;
        any_req      = |cause;
    end

    rpc_pulse_timer #(.PULSE_MS(PULSE_MS)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .ms_tick     (ms_tick),
        .req         (any_req),
        .active      (pin_drive_en),
        .release_stb (rst_release)
    );

    rpc_cause_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_por  (cause.supply || cause.manual),
        .set_wtr  (cause.wdog),
        .wr_en    (reg_wr),
        .keep_por (reg_wdata[POR_POS]),
        .keep_wtr (reg_wdata[WTR_POS]),
        .rdata    (reg_rdata)
    );

    // R2
    manual_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        manual_req |=> pin_drive_en);
    // R10
    supply_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |=> pin_drive_en);
    // R5
    wdog_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wdog_fault && !wdog_allow && !supply_low && !manual_req && !pin_drive_en)
        |=> !pin_drive_en);
    // R7
    spare_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[POR_POS-1:0] == '0);
endmodule

// File: tb/rst_pulse_ctrl_tb.sv
module rst_pulse_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_tick = 1'b0;
    logic       sw_n = 1'b1;
    logic       pin_sense_n;
    logic       supply_low = 1'b0;
    logic       wdog_fault = 1'b0;
    logic       wdog_allow = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'hFF;
    logic [7:0] reg_rdata;
    logic       pin_drive_en;
    logic       rst_release;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    typedef struct {
        string      tag;
        int         sel;   // 0 drive, 1 release, 2 status byte
        logic [7:0] exp;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    // wired-AND pin: switch or block can pull it low
    assign pin_sense_n = sw_n & ~pin_drive_en;

    rst_pulse_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pin_sense_n(pin_sense_n),
        .supply_low(supply_low), .wdog_fault(wdog_fault), .wdog_allow(wdog_allow),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_drive_en(pin_drive_en), .rst_release(rst_release)
    );

    // Monitor: compare queued expectations away from the active edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb_q.pop_front();
            case (it.sel)
                0:       act = {7'd0, pin_drive_en};
                1:       act = {7'd0, rst_release};
                default: act = reg_rdata;
            endcase
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic tick();
        ms_tick = 1'b1;
        cyc();
        ms_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            idle(3);
            tick();
        end
    endtask

    task automatic expect_item(input string tag, input int sel, input logic [7:0] exp);
        item_t it;
        it.tag = tag;
        it.sel = sel;
        it.exp = exp;
        sb_q.push_back(it);
    endtask

    task automatic write_reg(input logic [7:0] d);
        reg_wr    = 1'b1;
        reg_wdata = d;
        cyc();
        reg_wr    = 1'b0;
        reg_wdata = 8'hFF;
    endtask

    task automatic wd_pulse();
        wdog_fault = 1'b1;
        cyc();
        wdog_fault = 1'b0;
    endtask

    initial begin
        idle(5);
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        expect_item("R1 drive", 0, 8'h00);
        expect_item("R1 release", 1, 8'h00);
        expect_item("R1 status", 2, 8'h00);

        // R2 manual debounce, R3 pulse length, R6 flag
        sw_n = 1'b0;
        ticks(3);
        expect_item("R2 three ticks no drive", 0, 8'h00);
        ticks(1);
        expect_item("R2 fourth tick drives", 0, 8'h01);
        expect_item("R6 manual sets bit6", 2, 8'h40);
        sw_n = 1'b1;
        ticks(100);
        expect_item("R3 held at tick 100", 0, 8'h01);
        expect_item("R4 own low ignored", 0, 8'h01);
        ticks(1);
        expect_item("R3 released at tick 101", 0, 8'h00);
        expect_item("R12 release strobe", 1, 8'h01);
        cyc();
        expect_item("R12 strobe one cycle", 1, 8'h00);
        ticks(10);
        expect_item("R4 no retrigger after release", 0, 8'h00);

        // R2 interrupted run
        sw_n = 1'b0;
        ticks(3);
        sw_n = 1'b1;
        cyc();
        sw_n = 1'b0;
        ticks(3);
        expect_item("R2 interrupted run no drive", 0, 8'h00);
        ticks(1);
        expect_item("R2 fresh run drives", 0, 8'h01);
        sw_n = 1'b1;
        ticks(101);
        expect_item("R3 second pulse ends", 0, 8'h00);

        // R8 clear
        write_reg(8'h00);
        expect_item("R8 clear power flag", 2, 8'h00);

        // R5 watchdog blocked
        wdog_allow = 1'b0;
        wd_pulse();
        idle(2);
        expect_item("R5 blocked no drive", 0, 8'h00);
        expect_item("R5 blocked no flag", 2, 8'h00);

        // R5/R7 allowed watchdog, R9 extension
        wdog_allow = 1'b1;
        wd_pulse();
        expect_item("R5 allowed drives", 0, 8'h01);
        expect_item("R7 watchdog sets bit7", 2, 8'h80);
        ticks(50);
        wd_pulse();
        ticks(100);
        expect_item("R9 extended held", 0, 8'h01);
        ticks(1);
        expect_item("R9 extended ends", 0, 8'h00);

        // R10 supply low held, R11 set beats clear
        supply_low = 1'b1;
        cyc();
        expect_item("R10 supply drives", 0, 8'h01);
        expect_item("R7 both flags", 2, 8'hC0);
        ticks(200);
        expect_item("R10 held while low", 0, 8'h01);
        write_reg(8'h80);
        expect_item("R11 power set beats clear", 2, 8'hC0);
        supply_low = 1'b0;
        ticks(100);
        expect_item("R10 held after clear", 0, 8'h01);
        ticks(1);
        expect_item("R10 released at tick 101", 0, 8'h00);
        write_reg(8'h80);
        expect_item("R8 clear power keep watchdog", 2, 8'h80);

        // R11 watchdog set and clear in same cycle
        write_reg(8'h00);
        expect_item("R8 clear all", 2, 8'h00);
        wdog_fault = 1'b1;
        write_reg(8'h00);
        wdog_fault = 1'b0;
        expect_item("R11 watchdog set beats clear", 2, 8'h80);
        write_reg(8'h00);
        expect_item("R8 clear after collision", 2, 8'h00);
        ticks(101);
        expect_item("R3 final pulse ends", 0, 8'h00);

        idle(2);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule